// File: doc/BRIEF.md
# Chroma-to-Luma Timing Aligner

This block sits in a component-video pixel path that carries luma and chroma as separate sample streams (4:2:2, so one chroma pixel, a Cb/Cr pair, spans two luma sample periods). It moves chroma in time relative to luma by a programmable whole number of chroma pixels. The range runs from two chroma pixels earlier to three chroma pixels later. The shift is chosen by a 3-bit code.

Both outputs stay causal. Luma always passes through a fixed base delay of two chroma pixels (four samples). Chroma is delayed by that base plus or minus the selected shift, so its delay runs from 0 to 10 samples. Both delay lines advance only on samples flagged by the valid strobe, so gaps in the stream do not disturb alignment. A phase marker flags the first (Cb) sample of each chroma pixel. A new code is adopted only on such a sample, which keeps every Cb/Cr pair together.

Top module: `cl_align`

## Requirements
- R1: While rst_ni is low, and after its release until the first valid sample, valid_o is 0 and luma_o and chroma_o are 0.
- R2: For the n-th valid input sample (n counted from 0 after reset), with n >= 4, valid_o is 1 in the cycle after that sample and luma_o equals the luma of sample n-4.
- R3: The first four valid samples after reset produce valid_o = 0.
- R4: With code 3'b011, chroma_o for sample n is the chroma of sample n-4, the same delay as luma. This is the default setting after reset.
- R5: Code 3'b001 gives chroma a delay of 0 samples (two chroma pixels early). Code 3'b010 gives 2 samples (one chroma pixel early).
- R6: Codes 3'b100, 3'b101 and 3'b110 give chroma delays of 6, 8 and 10 samples (one, two and three chroma pixels late).
- R7: The reserved codes 3'b000 and 3'b111 behave as 3'b011.
- R8: A code is sampled only on a valid sample with phase_i = 1 and applies to that sample and the one after it. A code presented on a sample with phase_i = 0 has no effect until the next phase_i = 1 sample.
- R9: A cycle with valid_i = 0 gives valid_o = 0 in the next cycle, leaves luma_o and chroma_o unchanged, and does not advance either delay line.
- R10: A chroma output that would come from a sample before the first one after reset is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input sample strobe |
| phase_i | input | 1 | 1 on the first (Cb) sample of a chroma pixel |
| code_i | input | 3 | Chroma shift select |
| luma_i | input | DATA_W | Luma sample |
| chroma_i | input | DATA_W | Chroma sample (Cb or Cr) |
| valid_o | output | 1 | Output sample strobe |
| luma_o | output | DATA_W | Delayed luma |
| chroma_o | output | DATA_W | Shifted chroma |

## Verification
Two events can fall on the same valid sample: a change of the shift code and the start of a chroma pixel. The bench provokes this by presenting a new code on a phase_i = 1 sample, where the new delay must apply at once to that sample. It also presents a new code on a phase_i = 0 sample, where the old delay must hold for the rest of the pair. Each output sample is compared with a reference built from the sample index, the phase at which the code was taken, and the zero history left by reset. Idle cycles are placed inside a stream so that hold and resumption can be checked at the same time.

// File: rtl/cl_align_pkg.sv
package cl_align_pkg;

  localparam int unsigned CODE_W = 3;

  typedef enum logic [CODE_W-1:0] {
    SHIFT_RSV_LO = 3'b000,
    SHIFT_ERL_2  = 3'b001,
    SHIFT_ERL_1  = 3'b010,
    SHIFT_NONE   = 3'b011,
    SHIFT_LATE_1 = 3'b100,
    SHIFT_LATE_2 = 3'b101,
    SHIFT_LATE_3 = 3'b110,
    SHIFT_RSV_HI = 3'b111
  } shift_code_e;

  // Chroma delay in chroma pixels, base (no shift) = early_px.
  function automatic int unsigned chroma_px(input logic [CODE_W-1:0] code,
                                            input int unsigned early_px);
    case (shift_code_e'(code))
      SHIFT_ERL_2:  chroma_px = early_px - 2;
      SHIFT_ERL_1:  chroma_px = early_px - 1;
      SHIFT_LATE_1: chroma_px = early_px + 1;
      SHIFT_LATE_2: chroma_px = early_px + 2;
      SHIFT_LATE_3: chroma_px = early_px + 3;
      default:      chroma_px = early_px;
    endcase
  endfunction

endpackage

// File: rtl/cl_tap_line.sv
module cl_tap_line #(
  parameter int unsigned WIDTH = 10,
  parameter int unsigned DEPTH = 4
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        en_i,
  input  logic [WIDTH-1:0]            din_i,
  output logic [DEPTH:0][WIDTH-1:0]   taps_o
);

  logic [DEPTH-1:0][WIDTH-1:0] stage_q;

  assign taps_o[0] = din_i;

  for (genvar k = 0; k < DEPTH; k++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stage_q[k] <= '0;
      end else if (en_i) begin
        stage_q[k] <= taps_o[k];
      end
    end
    assign taps_o[k+1] = stage_q[k];
  end

  AST_LINE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(stage_q)) else $error("line advanced without strobe"); // R9

endmodule

// File: rtl/cl_shift_ctrl.sv
module cl_shift_ctrl #(
  parameter int unsigned PIX_SAMPLES = 2,
  parameter int unsigned EARLY_PX    = 2,
  parameter int unsigned LATE_PX     = 3,
  parameter int unsigned LUMA_LAT    = EARLY_PX * PIX_SAMPLES,
  parameter int unsigned CHROMA_MAX  = (EARLY_PX + LATE_PX) * PIX_SAMPLES,
  parameter int unsigned SEL_W       = $clog2(CHROMA_MAX + 1)
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              valid_i,
  input  logic                              phase_i,
  input  logic [cl_align_pkg::CODE_W-1:0]   code_i,
  output logic [SEL_W-1:0]                  sel_o,
  output logic                              filled_o
);

  localparam int unsigned FILL_W = $clog2(LUMA_LAT + 1);
  localparam logic [SEL_W-1:0] BASE_SEL = SEL_W'(LUMA_LAT);

  logic [SEL_W-1:0]  act_q;
  logic [SEL_W-1:0]  req_sel;
  logic [FILL_W-1:0] fill_q;

  assign req_sel  = SEL_W'(cl_align_pkg::chroma_px(code_i, EARLY_PX) * PIX_SAMPLES);
  // New code only on the first sample of a chroma pixel.
  assign sel_o    = (valid_i && phase_i) ? req_sel : act_q;
  assign filled_o = (fill_q == FILL_W'(LUMA_LAT));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= BASE_SEL;
      fill_q <= '0;
    end else if (valid_i) begin
      act_q <= sel_o;
      if (!filled_o) fill_q <= fill_q + 1'b1;
    end
  end

  AST_PAIR_SAME_DELAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !phase_i && $past(valid_i && phase_i)) |-> sel_o == $past(sel_o))
    else $error("pixel pair split"); // R8
  AST_FILL_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_q <= FILL_W'(LUMA_LAT)) else $error("fill overrun"); // R3
  AST_SEL_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_o <= SEL_W'(CHROMA_MAX)) else $error("delay out of range"); // R6

endmodule

// File: rtl/cl_align.sv
module cl_align #(
  parameter int unsigned DATA_W      = 10,
  parameter int unsigned PIX_SAMPLES = 2,
  parameter int unsigned EARLY_PX    = 2,
  parameter int unsigned LATE_PX     = 3
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              valid_i,
  input  logic                              phase_i,
  input  logic [cl_align_pkg::CODE_W-1:0]   code_i,
  input  logic [DATA_W-1:0]                 luma_i,
  input  logic [DATA_W-1:0]                 chroma_i,
  output logic                              valid_o,
  output logic [DATA_W-1:0]                 luma_o,
  output logic [DATA_W-1:0]                 chroma_o
);

  localparam int unsigned LUMA_LAT   = EARLY_PX * PIX_SAMPLES;
  localparam int unsigned CHROMA_MAX = (EARLY_PX + LATE_PX) * PIX_SAMPLES;
  localparam int unsigned SEL_W      = $clog2(CHROMA_MAX + 1);

  logic [LUMA_LAT:0][DATA_W-1:0]   luma_taps;
  logic [CHROMA_MAX:0][DATA_W-1:0] chroma_taps;
  logic [SEL_W-1:0]                sel;
  logic                            filled;

  cl_shift_ctrl #(
    .PIX_SAMPLES(PIX_SAMPLES),
    .EARLY_PX   (EARLY_PX),
    .LATE_PX    (LATE_PX),
    .LUMA_LAT   (LUMA_LAT),
    .CHROMA_MAX (CHROMA_MAX),
    .SEL_W      (SEL_W)
  ) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .phase_i (phase_i),
    .code_i  (code_i),
    .sel_o   (sel),
    .filled_o(filled)
  );

  cl_tap_line #(.WIDTH(DATA_W), .DEPTH(LUMA_LAT)) u_luma_line (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (valid_i),
    .din_i (luma_i),
    .taps_o(luma_taps)
  );

  cl_tap_line #(.WIDTH(DATA_W), .DEPTH(CHROMA_MAX)) u_chroma_line (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (valid_i),
    .din_i (chroma_i),
    .taps_o(chroma_taps)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      luma_o   <= '0;
      chroma_o <= '0;
    end else begin
      valid_o <= valid_i && filled;
      if (valid_i) begin
        luma_o   <= luma_taps[LUMA_LAT];
        chroma_o <= chroma_taps[sel];
      end
    end
  end

  AST_IDLE_NO_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o) else $error("valid without input"); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(luma_o) && $stable(chroma_o))) else $error("output moved while idle"); // R9
  AST_VALID_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(valid_i)) else $error("valid_o without source"); // R2

endmodule

// File: tb/cl_align_test.sv
module cl_align_test;

  localparam int DW = 10;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic valid_i = 1'b0;
  logic phase_i = 1'b0;
  logic [2:0] code_i = 3'b011;
  logic [DW-1:0] luma_i = '0;
  logic [DW-1:0] chroma_i = '0;
  logic valid_o;
  logic [DW-1:0] luma_o, chroma_o;

  always #2 clk = ~clk; // 250 MHz

  cl_align #(.DATA_W(DW)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .phase_i(phase_i),
    .code_i(code_i), .luma_i(luma_i), .chroma_i(chroma_i),
    .valid_o(valid_o), .luma_o(luma_o), .chroma_o(chroma_o)
  );

  int checks = 0;
  int errors = 0;
  int n_in = 0;
  int model_d = 4;
  logic [DW-1:0] lh [0:4095];
  logic [DW-1:0] chh [0:4095];

  function automatic int dec(input logic [2:0] c);
    if (c >= 3'd1 && c <= 3'd6) return (int'(c) - 1) * 2;
    return 4;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0; valid_i = 1'b0; code_i = 3'b011;
    repeat (2) @(negedge clk);
    chk(valid_o == 1'b0, "R1", "valid_o in reset", int'(valid_o), 0);
    chk(luma_o == '0 && chroma_o == '0, "R1", "data in reset", int'(luma_o) + int'(chroma_o), 0);
    rst_ni = 1'b1;
    n_in = 0; model_d = 4;
  endtask

  task automatic send(input logic [2:0] code, input bit ph, input string tag);
    int n, d;
    logic [DW-1:0] l, c;
    n = n_in;
    l = DW'((n * 37 + 5) % 1024);
    c = DW'((n * 59 + 300) % 1024);
    lh[n] = l; chh[n] = c;
    if (ph) model_d = dec(code);
    d = model_d;
    @(negedge clk);
    valid_i = 1'b1; phase_i = ph; code_i = code; luma_i = l; chroma_i = c;
    @(posedge clk); #1;
    valid_i = 1'b0;
    if (n >= 4) begin
      chk(valid_o == 1'b1, "R2", "valid_o", int'(valid_o), 1);
      chk(luma_o == lh[n-4], "R2", "luma_o", int'(luma_o), int'(lh[n-4]));
      if (n >= d)
        chk(chroma_o == chh[n-d], tag, "chroma_o", int'(chroma_o), int'(chh[n-d]));
      else
        chk(chroma_o == '0, "R10", "chroma_o history", int'(chroma_o), 0);
    end else begin
      chk(valid_o == 1'b0, "R3", "valid_o during fill", int'(valid_o), 0);
    end
    n_in++;
  endtask

  task automatic stream(input logic [2:0] code, input int cnt, input string tag);
    for (int i = 0; i < cnt; i++) send(code, (n_in % 2) == 0, tag);
  endtask

  task automatic idle(input int k);
    logic [DW-1:0] l0, c0;
    l0 = luma_o; c0 = chroma_o;
    for (int i = 0; i < k; i++) begin
      @(posedge clk); #1;
      chk(valid_o == 1'b0, "R9", "valid_o idle", int'(valid_o), 0);
      chk(luma_o == l0 && chroma_o == c0, "R9", "hold idle", int'(luma_o), int'(l0));
    end
  endtask

  task automatic t_reset();
    do_reset();
    @(posedge clk); #1;
    chk(valid_o == 1'b0, "R1", "valid_o after release", int'(valid_o), 0);
    chk(luma_o == '0 && chroma_o == '0, "R1", "data after release", int'(luma_o), 0);
  endtask

  task automatic t_default(); stream(3'b011, 12, "R4"); endtask

  task automatic t_early();
    stream(3'b001, 12, "R5");
    stream(3'b010, 12, "R5");
  endtask

  task automatic t_late();
    stream(3'b100, 12, "R6");
    stream(3'b101, 12, "R6");
    stream(3'b110, 14, "R6");
  endtask

  task automatic t_reserved();
    stream(3'b110, 12, "R6");
    stream(3'b000, 12, "R7");
    stream(3'b111, 12, "R7");
  endtask

  task automatic t_midpix();
    stream(3'b011, 12, "R8");
    send(3'b011, 1'b1, "R8");
    send(3'b101, 1'b0, "R8"); // ignored mid-pixel
    stream(3'b101, 12, "R8");
    send(3'b001, 1'b1, "R8"); // taken with the pixel start
    send(3'b001, 1'b0, "R8");
    send(3'b110, 1'b1, "R8");
    send(3'b010, 1'b0, "R8");
    stream(3'b110, 10, "R8");
  endtask

  task automatic t_gap();
    stream(3'b100, 8, "R9");
    idle(3);
    stream(3'b100, 3, "R9");
    idle(2);
    stream(3'b100, 9, "R9");
  endtask

  task automatic t_zero_hist();
    do_reset();
    stream(3'b110, 14, "R10");
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_default();
    t_early();
    t_late();
    t_reserved();
    t_midpix();
    t_gap();
    t_zero_hist();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule